// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block sits behind a network receive path and moves incoming frames into memory buffers. The buffers are described by a ring of descriptors that software builds and hands to hardware. Frames arrive one byte at a time, with a ready/valid handshake. The per-frame error and classification flags travel with the bytes and are taken from the byte that carries the end-of-frame marker. The engine packs the bytes into 32-bit words and writes them to the buffer named by the current descriptor. When it finishes with a descriptor, it writes status back into that descriptor's first word and returns it to software.

A frame longer than one buffer is spread across several descriptors. Only the first of these carries the first-segment mark. Only the last carries the last-segment mark, the total length and the flags. If the engine finds a software-owned descriptor, it reports that no buffer is available and waits for a poll-demand strobe before reading that descriptor again. Frames that arrive while it waits are discarded and reported as lost. A frame that runs out of descriptors part-way through has its remainder discarded.

Each descriptor occupies 16 bytes:
- Word 0, at offset 0, holds ownership and status.
- Word 1, at offset 4, holds the capacity and the ring-end mark.
- Word 2, at offset 8, holds the buffer address.

Top module: `rxwb_top`

## Requirements
- R1: After reset, memReq, inReady and every bit of intStatus are 0.
- R2: When ringEn rises, the engine reads the descriptor at ringBase. It uses a descriptor only if bit 31 of word 0 is 1. Reading a descriptor whose bit 31 is 0 produces a one-cycle pulse on intStatus bit 1 and causes no memory write.
- R3: Bytes are stored little-endian into 32-bit words written at consecutive word addresses, starting at the buffer address held in word 2. The word in progress is written when its four lanes are full, when the frame ends, or when the segment reaches capacity. Unfilled lanes are written as 0.
- R4: Word 1 bits 10:0 give the buffer capacity in bytes. When a frame fills a buffer and more bytes follow, word 0 is written back as 0 except for bit 29. Bit 29 is set only if this segment began the frame. The frame then continues in the next descriptor's buffer.
- R5: The descriptor that holds the end of a frame is written back with the following fields, and all other bits 0:
  - bit 31 = 0;
  - bit 28 = 1;
  - bit 29 = 1 if the frame began in this descriptor;
  - bits 10:0 = total frame length;
  - bits 22:16 = inFlags[6:0], with inFlags[6] landing in bit 22 and inFlags[0] in bit 16. The flag order is odd nibble, runt, too long, CRC error, receive error, broadcast, multicast.
- R6: Descriptors follow each other at a 16-byte stride. A descriptor whose word 1 bit 31 is 1 is followed by the descriptor at ringBase.
- R7: intStatus bit 6 pulses in the cycle the first byte of a frame is accepted into a buffer. intStatus bit 0 pulses in the cycle the write-back carrying bit 28 is granted.
- R8: If the descriptor after a filled buffer is software-owned in the middle of a frame, intStatus bit 1 pulses. The remaining bytes of that frame are accepted and discarded with no memory write, and intStatus bit 0 does not pulse.
- R9: While no owned descriptor is available, a frame's first byte produces a pulse on intStatus bit 7, and the frame is discarded. A pollDemand pulse makes the engine read the same descriptor again, and a failed read pulses bit 1 again.
- R10: A memory request holds memReq, memWe, memAddr and memWdata steady until memGnt is high in the same cycle. The read data is taken in that cycle.
- R11: A byte transfers only in a cycle with inValid and inReady both high. After the last byte of a frame is stored, inReady drops until the data and the status have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringEn | input | 1 | Engine enable; rising starts at ringBase, low aborts to idle |
| ringBase | input | ADDR_W | Byte address of the first descriptor |
| pollDemand | input | 1 | Re-read the current descriptor while waiting for buffers |
| inValid | input | 1 | Receive byte valid |
| inReady | output | 1 | Engine takes the byte this cycle |
| inData | input | 8 | Receive byte |
| inLast | input | 1 | Byte ends the frame |
| inFlags | input | 7 | Frame flags, sampled with inLast |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memGnt is high |
| memGnt | input | 1 | Request completes this cycle |
| intStatus | output | 8 | Event pulses: bit 0 frame stored, bit 1 no buffer, bit 6 frame accepted, bit 7 frame lost |

## Verification
The hardest situation to reach is a frame that runs out of owned descriptors part-way through. Reaching it needs a multi-segment frame on short buffers followed by a descriptor software never returned. The bench gets there by re-arming only part of the ring: it gives the second descriptor a 4-byte buffer and leaves the third unowned, then sends a 10-byte frame. It also sends a frame whose length equals the buffer capacity exactly, and one that spans three descriptors with a 5-byte buffer in the middle, so a partial word is written before the segment closes. For part of the run the memory grant is stalled in a repeating pattern, so that requests are held waiting for a grant.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  // descriptor layout: word 0 status, word 1 control, word 2 buffer address
  localparam int DESC_STRIDE = 16;
  localparam int LEN_W       = 11;
  localparam int FLAG_W      = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_FETCH2, S_RECV,
    S_WRWORD, S_WRBACK, S_HUNGRY, S_SINK
  } state_t;

  typedef enum logic [1:0] {A_DESC0, A_DESC1, A_DESC2, A_WORD} addr_sel_t;

  typedef struct packed {
    addr_sel_t addrSel;
    logic      loadBase;
    logic      takeCtrl;
    logic      takeBuf;
    logic      takeByte;
    logic      startFrame;
    logic      wordDone;
    logic      segDone;
  } strobe_t;
endpackage

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
  import rxwb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ringEn,
  input  logic    pollDemand,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    memGnt,
  input  logic    ownBit,
  input  logic    byteEndsWord,
  input  logic    segFull,
  input  logic    frameEnded,
  output logic    memReq,
  output logic    memWe,
  output logic    inReady,
  output strobe_t stb,
  output logic [7:0] intStatus
);
  state_t state, nextState;
  logic inFrame;

  always_comb begin
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    inReady   = 1'b0;
    stb       = '0;
    intStatus = '0;
    if (!ringEn) begin
      nextState = S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          stb.loadBase = 1'b1;
          nextState    = S_FETCH0;
        end
        S_FETCH0: begin
          memReq      = 1'b1;
          stb.addrSel = A_DESC0;
          if (memGnt) begin
            if (ownBit) nextState = S_FETCH1;
            else begin
              intStatus[1] = 1'b1;
              nextState    = inFrame ? S_SINK : S_HUNGRY;
            end
          end
        end
        S_FETCH1: begin
          memReq      = 1'b1;
          stb.addrSel = A_DESC1;
          if (memGnt) begin
            stb.takeCtrl = 1'b1;
            nextState    = S_FETCH2;
          end
        end
        S_FETCH2: begin
          memReq      = 1'b1;
          stb.addrSel = A_DESC2;
          if (memGnt) begin
            stb.takeBuf = 1'b1;
            nextState   = S_RECV;
          end
        end
        S_RECV: begin
          inReady = 1'b1;
          if (inValid) begin
            stb.takeByte = 1'b1;
            if (!inFrame) begin
              stb.startFrame = 1'b1;
              intStatus[6]   = 1'b1;
            end
            if (byteEndsWord) nextState = S_WRWORD;
          end
        end
        S_WRWORD: begin
          memReq      = 1'b1;
          memWe       = 1'b1;
          stb.addrSel = A_WORD;
          if (memGnt) begin
            stb.wordDone = 1'b1;
            nextState    = (frameEnded || segFull) ? S_WRBACK : S_RECV;
          end
        end
        S_WRBACK: begin
          memReq      = 1'b1;
          memWe       = 1'b1;
          stb.addrSel = A_DESC0;
          if (memGnt) begin
            stb.segDone  = 1'b1;
            intStatus[0] = frameEnded;
            nextState    = S_FETCH0;
          end
        end
        S_HUNGRY: begin
          inReady = 1'b1;
          if (inValid) begin
            intStatus[7] = 1'b1;
            if (!inLast) nextState = S_SINK;
          end else if (pollDemand) begin
            nextState = S_FETCH0;
          end
        end
        S_SINK: begin
          inReady = 1'b1;
          if (inValid && inLast) nextState = S_HUNGRY;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      inFrame <= 1'b0;
    end else begin
      state <= nextState;
      if (!ringEn) inFrame <= 1'b0;
      else if (stb.startFrame) inFrame <= 1'b1;
      else if (stb.segDone && frameEnded) inFrame <= 1'b0;
      else if (state == S_SINK && inValid && inLast) inFrame <= 1'b0;
    end
  end

  // R11: once the closing byte is stored, no further byte is taken next cycle
  p_hold_after_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RECV && inValid && inLast) |=> !inReady);

  // R8: a failed fetch never leads straight into a memory write
  p_nobuf_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[1] |=> !memWe);
endmodule

// File: rtl/rxwb_dpath.sv
module rxwb_dpath
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [FLAG_W-1:0] inFlags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              byteEndsWord,
  output logic              segFull,
  output logic              frameEnded
);
  logic [ADDR_W-1:0] descAddr, wordAddr;
  logic [LEN_W-1:0]  capacity, segCnt, frameLen;
  logic              ringEnd, firstSeg, endedR;
  logic [1:0]        lane;
  logic [31:0]       wordData, backWord;
  logic [FLAG_W-1:0] flagsR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
      wordAddr <= '0;
      capacity <= '0;
      segCnt   <= '0;
      frameLen <= '0;
      ringEnd  <= 1'b0;
      firstSeg <= 1'b0;
      endedR   <= 1'b0;
      lane     <= '0;
      wordData <= '0;
      flagsR   <= '0;
    end else begin
      if (stb.loadBase) descAddr <= ringBase;
      if (stb.takeCtrl) begin
        capacity <= memRdata[LEN_W-1:0];
        ringEnd  <= memRdata[31];
      end
      if (stb.takeBuf) begin
        wordAddr <= memRdata[ADDR_W-1:0];
        segCnt   <= '0;
        lane     <= '0;
        wordData <= '0;
      end
      if (stb.takeByte) begin
        wordData[{lane, 3'b000} +: 8] <= inData;
        lane   <= lane + 2'd1;
        segCnt <= segCnt + LEN_W'(1);
        if (stb.startFrame) begin
          frameLen <= LEN_W'(1);
          firstSeg <= 1'b1;
          endedR   <= inLast;
        end else begin
          frameLen <= frameLen + LEN_W'(1);
          if (inLast) endedR <= 1'b1;
        end
        if (inLast) flagsR <= inFlags;
      end
      if (stb.wordDone) begin
        wordAddr <= wordAddr + ADDR_W'(4);
        lane     <= '0;
        wordData <= '0;
      end
      if (stb.segDone) begin
        descAddr <= ringEnd ? ringBase : descAddr + ADDR_W'(DESC_STRIDE);
        firstSeg <= 1'b0;
      end
    end
  end

  always_comb begin
    backWord        = '0;
    backWord[29]    = firstSeg;
    backWord[28]    = endedR;
    if (endedR) begin
      backWord[22:16]      = flagsR;
      backWord[LEN_W-1:0]  = frameLen;
    end
  end

  always_comb begin
    case (stb.addrSel)
      A_DESC1: memAddr = descAddr + ADDR_W'(4);
      A_DESC2: memAddr = descAddr + ADDR_W'(8);
      A_WORD:  memAddr = wordAddr;
      default: memAddr = descAddr;
    endcase
  end

  assign memWdata     = (stb.addrSel == A_WORD) ? wordData : backWord;
  assign byteEndsWord = (lane == 2'd3) || inLast || ((segCnt + LEN_W'(1)) == capacity);
  assign segFull      = (segCnt == capacity);
  assign frameEnded   = endedR;

  // R4: a byte is only stored while the current buffer still has room
  p_room_for_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeByte |-> (segCnt < capacity));
endmodule

// File: rtl/rxwb_top.sv
module rxwb_top
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringEn,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              pollDemand,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [6:0]        inFlags,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memGnt,
  output logic [7:0]        intStatus
);
  strobe_t stb;
  logic byteEndsWord, segFull, frameEnded;

  rxwb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ringEn(ringEn), .pollDemand(pollDemand),
    .inValid(inValid), .inLast(inLast), .memGnt(memGnt), .ownBit(memRdata[31]),
    .byteEndsWord(byteEndsWord), .segFull(segFull), .frameEnded(frameEnded),
    .memReq(memReq), .memWe(memWe), .inReady(inReady), .stb(stb),
    .intStatus(intStatus)
  );

  rxwb_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBase(ringBase), .memRdata(memRdata),
    .inData(inData), .inLast(inLast), .inFlags(inFlags), .memAddr(memAddr),
    .memWdata(memWdata), .byteEndsWord(byteEndsWord), .segFull(segFull),
    .frameEnded(frameEnded)
  );

  // R10: a waiting request keeps its address and data until granted
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (!ringEn || (memReq && $stable(memAddr) && $stable(memWdata))));

  // R7: the stored-frame pulse coincides with a granted closing write-back
  p_done_on_close_r7: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[0] |-> (memReq && memWe && memGnt && memWdata[28] && !memWdata[31]));
endmodule

// File: tb/rxwb_top_tb_top.sv
`timescale 1ns/1ps
module rxwb_top_tb_top;
  localparam logic [31:0] BASE = 32'h100;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringEn = 1'b0, pollDemand = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic [6:0] inFlags = '0;
  logic inReady, memReq, memWe, memGnt;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [7:0] intStatus;

  logic [31:0] mem [0:1023];
  logic [31:0] cyc = '0;
  logic stallOn = 1'b0;

  int vecCnt = 0, errCnt = 0;
  string phase = "R2";

  // reference model state (software view of the ring)
  bit mOwn [NDESC];
  int mCap [NDESC];
  int mBuf [NDESC];
  bit mEnd [NDESC];
  int mPtr = 0;
  bit mHungry = 0;
  logic [31:0] wrAddrQ[$], wrDataQ[$];
  logic [7:0] evQ[$];

  always #10 clk = ~clk;

  rxwb_top dut_i (
    .clk(clk), .rstN(rstN), .ringEn(ringEn), .ringBase(BASE), .pollDemand(pollDemand),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast), .inFlags(inFlags),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memGnt(memGnt), .intStatus(intStatus)
  );

  assign memGnt   = !stallOn || (cyc[1:0] != 2'd0);
  assign memRdata = mem[memAddr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && memReq && memWe && memGnt) mem[memAddr[11:2]] <= memWdata;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s (phase %s): actual %h expected %h", req, phase, act, exp);
    end
  endtask

  // per-clock comparison against the model queues
  logic prevStall = 1'b0;
  logic [31:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memWe && memGnt) begin
        if (wrAddrQ.size() == 0) check(1'b0, "R3", memAddr, 32'hx);
        else begin
          logic [31:0] ea, ed;
          string tag;
          ea = wrAddrQ.pop_front();
          ed = wrDataQ.pop_front();
          tag = (ea >= 32'h400) ? "R3" : (ed[28] ? "R5" : "R4");
          check(memAddr == ea, tag, memAddr, ea);
          check(memWdata == ed, tag, memWdata, ed);
        end
      end
      if (intStatus != 0) begin
        if (evQ.size() == 0) check(1'b0, "R7", {24'h0, intStatus}, 32'h0);
        else begin
          logic [7:0] ee;
          ee = evQ.pop_front();
          check(intStatus == ee, (ee == 8'h80) ? "R9" : (ee == 8'h02) ? "R8" : "R7",
                {24'h0, intStatus}, {24'h0, ee});
        end
      end
      if (prevStall && ringEn)
        check(memReq && memAddr == prevAddr, "R10", memAddr, prevAddr);
      prevStall = memReq && !memGnt;
      prevAddr  = memAddr;
    end
  end

  function automatic logic [31:0] descAddr(int i);
    return BASE + 32'(16 * i);
  endfunction

  task automatic arm(int i, int cap);
    mem[descAddr(i) >> 2]       = 32'h8000_0000;
    mem[(descAddr(i) >> 2) + 1] = {mEnd[i], 20'h0, 11'(cap)};
    mem[(descAddr(i) >> 2) + 2] = 32'h400 + 32'(i * 32'h80);
    mOwn[i] = 1; mCap[i] = cap; mBuf[i] = 32'h400 + i * 32'h80;
  endtask

  task automatic modelFetch();
    if (!mOwn[mPtr]) begin
      evQ.push_back(8'h02);
      mHungry = 1;
    end else mHungry = 0;
  endtask

  task automatic modelAdvance();
    mOwn[mPtr] = 0;
    mPtr = mEnd[mPtr] ? 0 : mPtr + 1;
    modelFetch();
  endtask

  task automatic modelFrame(int len, logic [6:0] fl, logic [7:0] seed);
    int seg, lane, wa;
    bit first;
    logic [31:0] w;
    if (mHungry) begin evQ.push_back(8'h80); return; end
    evQ.push_back(8'h40);
    seg = 0; lane = 0; w = 0; first = 1; wa = mBuf[mPtr];
    for (int i = 0; i < len; i++) begin
      bit lastB;
      lastB = (i == len - 1);
      w[8*lane +: 8] = seed + 8'(i);
      lane++; seg++;
      if (lane == 4 || lastB || seg == mCap[mPtr]) begin
        wrAddrQ.push_back(32'(wa)); wrDataQ.push_back(w);
        wa += 4; w = 0; lane = 0;
      end
      if (lastB) begin
        wrAddrQ.push_back(descAddr(mPtr));
        wrDataQ.push_back((32'(first) << 29) | (32'h1 << 28) | (32'(fl) << 16) | 32'(len));
        evQ.push_back(8'h01);
        modelAdvance();
      end else if (seg == mCap[mPtr]) begin
        wrAddrQ.push_back(descAddr(mPtr));
        wrDataQ.push_back(32'(first) << 29);
        first = 0;
        modelAdvance();
        if (mHungry) return;
        seg = 0; wa = mBuf[mPtr];
      end
    end
  endtask

  task automatic putByte(logic [7:0] d, logic l, logic [6:0] f);
    inValid = 1'b1; inData = d; inLast = l; inFlags = f;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(int len, logic [6:0] fl, logic [7:0] seed);
    modelFrame(len, fl, seed);
    for (int i = 0; i < len; i++) putByte(seed + 8'(i), i == len - 1, fl);
    idle(60);
  endtask

  task automatic poll();
    modelFetch();
    pollDemand = 1'b1;
    @(posedge clk); #1;
    pollDemand = 1'b0;
    idle(20);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < NDESC; i++) begin mOwn[i] = 0; mEnd[i] = (i == NDESC - 1); end
    idle(3);
    // R1: reset values
    check(memReq == 1'b0, "R1", {31'h0, memReq}, 32'h0);
    check(inReady == 1'b0, "R1", {31'h0, inReady}, 32'h0);
    check(intStatus == 8'h0, "R1", {24'h0, intStatus}, 32'h0);
    rstN = 1'b1;
    idle(2);

    arm(0, 64); arm(1, 8); arm(2, 5); arm(3, 64);
    phase = "R2";
    mPtr = 0; modelFetch();
    ringEn = 1'b1;
    idle(10);

    phase = "R5";
    sendFrame(13, 7'b0000010, 8'h10);          // fits in one buffer, broadcast
    phase = "R6";
    stallOn = 1'b1;                              // R10 stalls from here on
    sendFrame(20, 7'b1010001, 8'h40);          // three segments, wraps, then no buffer
    phase = "R9";
    poll();                                      // still unowned: no-buffer again
    sendFrame(6, 7'b0, 8'h70);                  // lost while waiting
    arm(0, 12); arm(1, 4);
    poll();
    phase = "R4";
    sendFrame(12, 7'b0001000, 8'h90);          // length equals capacity exactly
    phase = "R8";
    sendFrame(10, 7'b0000100, 8'hA0);          // second buffer short, third unowned
    phase = "R9";
    sendFrame(3, 7'b0, 8'hC0);                  // lost
    stallOn = 1'b0;
    arm(2, 64);
    poll();
    phase = "R11";
    sendFrame(1, 7'b0000001, 8'hE0);           // single byte, partial word, multicast
    idle(20);

    check(wrAddrQ.size() == 0, "R3", 32'(wrAddrQ.size()), 32'h0);
    check(evQ.size() == 0, "R7", 32'(evQ.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog (phase %s): actual running expected finished", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule